// File: doc/BRIEF.md
# Nine-level stacked-carrier PWM comparator bank

This block turns three signed phase-reference samples into the switching pattern of a three-phase, nine-level cascaded bridge converter. One programmable up/down counter produces a symmetrical digital triangle. From it the block derives eight carriers of equal height and frequency. The carriers sit in eight adjacent amplitude bands that together cover the span from -4H to +4H, where H is the programmed half-period.

Every phase reference is compared against all eight carriers. Each phase yields an eight-bit comparison vector and a signed level from -4 to +4. The level is the number of carriers lying below the reference, minus four.

A two-bit mode input sets the direction of each band's triangle from the band's position in the stack. In one mode all bands rise together. In another all bands fall together. In a third the upper and lower halves run in opposition. In the fourth the direction alternates from band to band. A new mode and a new half-period both take effect only at a carrier period boundary, so the carrier bank never shows a partial period.

Top module: `mcpwm_level_gen`

## Requirements
- R1: Band k (k = 0 lowest … 7 highest) spans [(k-4)·H, (k-3)·H]. Bit k of each comparison vector is the result for band k.
- R2: The shared count runs 0,1,…,H,H-1,…,1,0,1,…, so one carrier period is 2H cycles. A half-period input of 0 is treated as 1.
- R3: With mode code 0, every band is non-inverted: carrier = band bottom + count.
- R4: With mode code 1, every band is inverted: carrier = band top − count.
- R5: With mode code 2, bands 4–7 are non-inverted and bands 0–3 are inverted.
- R6: With mode code 3, odd-numbered bands are inverted and even-numbered bands are non-inverted.
- R7: A comparison bit is 1 only when the signed reference is strictly greater than its carrier. Equality gives 0.
- R8: Each level output is a 4-bit two's-complement value equal to the number of set bits in its phase's vector minus 4.
- R9: The three phases share one carrier bank. Each phase's outputs depend only on that phase's own reference.
- R10: The mode and the half-period are captured only on the clock edge where the count goes from 1 to 0, and during reset. Changes at any other time have no effect until the next such edge.
- R11: Outputs are registered. They reflect the references and the carrier state present at the previous rising clock edge.
- R12: Synchronous active-low reset clears every comparison vector to 0 and sets every level to -4. It sets the count to 0, rising, and loads the mode and half-period from the inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| half_period | input | CNT_W | Carrier half-period H in cycles (0 treated as 1) |
| mode_sel | input | 2 | Band phase pattern: 0 aligned, 1 all inverted, 2 halves opposed, 3 alternating |
| ref_a | input | REF_W | Phase A reference, signed |
| ref_b | input | REF_W | Phase B reference, signed |
| ref_c | input | REF_W | Phase C reference, signed |
| cmp_a | output | NUM_LEVELS-1 | Phase A comparison vector, bit k for band k |
| cmp_b | output | NUM_LEVELS-1 | Phase B comparison vector |
| cmp_c | output | NUM_LEVELS-1 | Phase C comparison vector |
| level_a | output | 4 | Phase A level, signed -4..+4 |
| level_b | output | 4 | Phase B level, signed |
| level_c | output | 4 | Phase C level, signed |

## Verification
Every cycle, the assertions check the following:
- The count moves by exactly one step and stays within 0..H.
- The captured mode and half-period stay unchanged away from the count-zero cycle.
- Each comparison vector is a thermometer code filled from band 0 upward.
- Each level stays in -4..+4.
- Two phases given equal references produce equal vectors.

Only the bench's scenarios can confirm the following:
- Each mode inverts exactly the right bands.
- A tie with a carrier gives 0.
- A mode or half-period change made mid-period is deferred.
- The outputs follow the inputs with one cycle of delay.

// File: rtl/mcpwm_pkg.sv
package mcpwm_pkg;

    // Band phase pattern selected by mode_sel
    typedef enum logic [1:0] {
        DISP_ALIGNED   = 2'd0,
        DISP_FLIPPED   = 2'd1,
        DISP_SPLIT     = 2'd2,
        DISP_ALTERNATE = 2'd3
    } disp_e;

    // True when band 'band' of 'nbands' runs its triangle mirrored
    function automatic logic band_mirrored(disp_e m, int band, int nbands);
        logic mir;
        case (m)
            DISP_ALIGNED:   mir = 1'b0;
            DISP_FLIPPED:   mir = 1'b1;
            DISP_SPLIT:     mir = (band < nbands / 2);
            default:        mir = ((band % 2) == 1);
        endcase
        return mir;
    endfunction

endpackage

// File: rtl/mcpwm_tri_gen.sv
module mcpwm_tri_gen
    import mcpwm_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] half_period_i,
    input  logic [1:0]       mode_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic [CNT_W-1:0] half_o,
    output disp_e            mode_o
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             down;
        logic [CNT_W-1:0] half;
        disp_e            mode;
    } tri_state_t;

    tri_state_t st_d, st_q;
    logic [CNT_W-1:0] half_in;

    always_comb begin
        half_in = (half_period_i == '0) ? CNT_W'(1) : half_period_i;
        st_d    = st_q;
        if (!rst_n) begin
            st_d.cnt  = '0;
            st_d.down = 1'b0;
            st_d.half = half_in;
            st_d.mode = disp_e'(mode_i);
        end else if (!st_q.down) begin
            st_d.cnt = st_q.cnt + 1'b1;
            if ((st_q.cnt + 1'b1) >= st_q.half) begin
                st_d.down = 1'b1;
            end
        end else begin
            st_d.cnt = st_q.cnt - 1'b1;
            if (st_q.cnt == CNT_W'(1)) begin
                // entering the trough: period boundary, capture settings
                st_d.down = 1'b0;
                st_d.half = half_in;
                st_d.mode = disp_e'(mode_i);
            end
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign cnt_o  = st_q.cnt;
    assign half_o = st_q.half;
    assign mode_o = st_q.mode;

endmodule

// File: rtl/mcpwm_carrier_bank.sv
module mcpwm_carrier_bank
    import mcpwm_pkg::*;
#(
    parameter int CNT_W = 8,
    parameter int NCAR  = 8,
    parameter int CAR_W = 12
) (
    input  logic [CNT_W-1:0]            cnt_i,
    input  logic [CNT_W-1:0]            half_i,
    input  disp_e                       mode_i,
    output logic [NCAR-1:0][CAR_W-1:0]  car_o
);

    localparam int HALF_N = NCAR / 2;

    for (genvar k = 0; k < NCAR; k++) begin : g_band
        int h_i;
        int c_i;
        int v_i;
        always_comb begin
            h_i = int'(half_i);
            c_i = int'(cnt_i);
            v_i = (k - HALF_N) * h_i;
            if (band_mirrored(mode_i, k, NCAR)) begin
                v_i = v_i + h_i - c_i;
            end else begin
                v_i = v_i + c_i;
            end
            car_o[k] = CAR_W'(v_i);
        end
    end

endmodule

// File: rtl/mcpwm_phase_cmp.sv
module mcpwm_phase_cmp #(
    parameter int NCAR  = 8,
    parameter int CAR_W = 12,
    parameter int REF_W = 12,
    parameter int LVL_W = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic signed [REF_W-1:0]    ref_i,
    input  logic [NCAR-1:0][CAR_W-1:0] car_i,
    output logic [NCAR-1:0]            bits_o,
    output logic signed [LVL_W-1:0]    level_o
);

    localparam int HALF_N = NCAR / 2;
    localparam int CMP_W  = ((REF_W > CAR_W) ? REF_W : CAR_W) + 1;

    typedef struct packed {
        logic [NCAR-1:0]  bits;
        logic [LVL_W-1:0] level;
    } cmp_state_t;

    cmp_state_t st_d, st_q;
    logic signed [CMP_W-1:0] ref_ext;
    logic [NCAR-1:0]         hit;
    logic [LVL_W-1:0]        ones;

    for (genvar k = 0; k < NCAR; k++) begin : g_cmp
        logic signed [CMP_W-1:0] car_ext;
        assign car_ext = CMP_W'($signed(car_i[k]));
        assign hit[k]  = (ref_ext > car_ext);
    end

    always_comb begin
        ref_ext = CMP_W'(ref_i);
        ones    = '0;
        for (int k = 0; k < NCAR; k++) begin
            ones = ones + LVL_W'(hit[k]);
        end
        if (!rst_n) begin
            st_d.bits  = '0;
            st_d.level = LVL_W'(-HALF_N);
        end else begin
            st_d.bits  = hit;
            st_d.level = ones - LVL_W'(HALF_N);
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign bits_o  = st_q.bits;
    assign level_o = st_q.level;

endmodule

// File: rtl/mcpwm_level_gen.sv
module mcpwm_level_gen
    import mcpwm_pkg::*;
#(
    parameter int CNT_W      = 8,
    parameter int REF_W      = 12,
    parameter int NUM_LEVELS = 9
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [CNT_W-1:0]            half_period,
    input  logic [1:0]                  mode_sel,
    input  logic signed [REF_W-1:0]     ref_a,
    input  logic signed [REF_W-1:0]     ref_b,
    input  logic signed [REF_W-1:0]     ref_c,
    output logic [NUM_LEVELS-2:0]       cmp_a,
    output logic [NUM_LEVELS-2:0]       cmp_b,
    output logic [NUM_LEVELS-2:0]       cmp_c,
    output logic signed [3:0]           level_a,
    output logic signed [3:0]           level_b,
    output logic signed [3:0]           level_c
);

    localparam int NCAR   = NUM_LEVELS - 1;
    localparam int HALF_N = NCAR / 2;
    localparam int CAR_W  = CNT_W + $clog2(NCAR) + 1;
    localparam int LVL_W  = $clog2(HALF_N + 1) + 1;

    logic [CNT_W-1:0]           tri_cnt;
    logic [CNT_W-1:0]           tri_half;
    disp_e                      tri_mode;
    logic [NCAR-1:0][CAR_W-1:0] carriers;

    logic signed [REF_W-1:0]    refs [3];
    logic [NCAR-1:0]            bits [3];
    logic signed [LVL_W-1:0]    lvls [3];

    mcpwm_tri_gen #(.CNT_W(CNT_W)) u_tri (
        .clk           (clk),
        .rst_n         (rst_n),
        .half_period_i (half_period),
        .mode_i        (mode_sel),
        .cnt_o         (tri_cnt),
        .half_o        (tri_half),
        .mode_o        (tri_mode)
    );

    mcpwm_carrier_bank #(.CNT_W(CNT_W), .NCAR(NCAR), .CAR_W(CAR_W)) u_bank (
        .cnt_i  (tri_cnt),
        .half_i (tri_half),
        .mode_i (tri_mode),
        .car_o  (carriers)
    );

    assign refs[0] = ref_a;
    assign refs[1] = ref_b;
    assign refs[2] = ref_c;

    for (genvar p = 0; p < 3; p++) begin : g_phase
        mcpwm_phase_cmp #(
            .NCAR(NCAR), .CAR_W(CAR_W), .REF_W(REF_W), .LVL_W(LVL_W)
        ) u_cmp (
            .clk     (clk),
            .rst_n   (rst_n),
            .ref_i   (refs[p]),
            .car_i   (carriers),
            .bits_o  (bits[p]),
            .level_o (lvls[p])
        );
    end

    assign cmp_a   = bits[0];
    assign cmp_b   = bits[1];
    assign cmp_c   = bits[2];
    assign level_a = 4'(lvls[0]);
    assign level_b = 4'(lvls[1]);
    assign level_c = 4'(lvls[2]);

endmodule

// File: rtl/mcpwm_level_gen_chk.sv
module mcpwm_level_gen_chk #(
    parameter int CNT_W = 8,
    parameter int REF_W = 12,
    parameter int NCAR  = 8
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic [CNT_W-1:0]        cnt,
    input logic [CNT_W-1:0]        half,
    input logic [1:0]              mode,
    input logic signed [REF_W-1:0] ref_a,
    input logic signed [REF_W-1:0] ref_b,
    input logic [NCAR-1:0]         cmp_a,
    input logic [NCAR-1:0]         cmp_b,
    input logic [NCAR-1:0]         cmp_c,
    input logic signed [3:0]       level_a
);

    localparam int HALF_N = NCAR / 2;

    logic [1:0] age_q;
    logic       settled;

    always_ff @(posedge clk) begin
        if (!rst_n)              age_q <= 2'd0;
        else if (age_q != 2'd3)  age_q <= age_q + 2'd1;
    end
    assign settled = (age_q >= 2'd2);

    // R2: count stays within the triangle and H is never zero
    assert_count_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        settled |-> (cnt <= half) && (half != '0));

    // R2: count moves one step per cycle
    assert_count_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        settled |-> (cnt == $past(cnt) + 1'b1) || (cnt == $past(cnt) - 1'b1));

    // R10: captured settings only change on entry to the trough
    assert_settings_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (settled && cnt != '0) |-> ($stable(mode) && $stable(half)));

    // R1: contiguous bands make every vector a thermometer code from bit 0
    assert_thermo_a_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_a & NCAR'(cmp_a + 1'b1)) == '0);
    assert_thermo_b_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_b & NCAR'(cmp_b + 1'b1)) == '0);
    assert_thermo_c_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_c & NCAR'(cmp_c + 1'b1)) == '0);

    // R8: level within the legal range
    assert_level_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(level_a) >= -HALF_N) && (int'(level_a) <= HALF_N));

    // R9: shared carriers give equal results for equal references
    assert_shared_bank_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (settled && $past(ref_a) == $past(ref_b)) |-> (cmp_a == cmp_b));

endmodule

bind mcpwm_level_gen mcpwm_level_gen_chk #(
    .CNT_W(CNT_W), .REF_W(REF_W), .NCAR(NUM_LEVELS - 1)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .cnt     (tri_cnt),
    .half    (tri_half),
    .mode    (tri_mode),
    .ref_a   (ref_a),
    .ref_b   (ref_b),
    .cmp_a   (cmp_a),
    .cmp_b   (cmp_b),
    .cmp_c   (cmp_c),
    .level_a (level_a)
);

// File: tb/tb_mcpwm_level_gen.sv
`timescale 1ns/1ps
module tb_mcpwm_level_gen;

    localparam int CNT_W = 8;
    localparam int REF_W = 12;
    localparam int NCAR  = 8;

    logic                    clk = 1'b0;
    logic                    rst_n = 1'b0;
    logic [CNT_W-1:0]        half_period = 8'd4;
    logic [1:0]              mode_sel = 2'd0;
    logic signed [REF_W-1:0] ref_a = '0, ref_b = '0, ref_c = '0;
    logic [NCAR-1:0]         cmp_a, cmp_b, cmp_c;
    logic signed [3:0]       level_a, level_b, level_c;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    always #10 clk = ~clk;  // 50 MHz

    mcpwm_level_gen dut (
        .clk(clk), .rst_n(rst_n), .half_period(half_period), .mode_sel(mode_sel),
        .ref_a(ref_a), .ref_b(ref_b), .ref_c(ref_c),
        .cmp_a(cmp_a), .cmp_b(cmp_b), .cmp_c(cmp_c),
        .level_a(level_a), .level_b(level_b), .level_c(level_c)
    );

    // ---------------- reference model from the requirements ----------------
    function automatic bit is_inv(int k, int mode);
        case (mode)
            0: return 1'b0;           // R3
            1: return 1'b1;           // R4
            2: return (k < 4);        // R5
            default: return (k % 2 == 1); // R6
        endcase
    endfunction

    function automatic int carrier(int k, int c, int h, int mode);
        return (k - 4) * h + (is_inv(k, mode) ? (h - c) : c);   // R1
    endfunction

    function automatic logic [7:0] exp_bits(int r, int c, int h, int mode);
        logic [7:0] b;
        for (int k = 0; k < 8; k++) b[k] = (r > carrier(k, c, h, mode)); // R7 strict
        return b;
    endfunction

    function automatic int exp_level(logic [7:0] b);
        int n = 0;
        for (int k = 0; k < 8; k++) n += int'(b[k]);
        return n - 4;   // R8
    endfunction

    int m_c, m_h, m_mode;
    bit m_down;
    logic [7:0] e_a, e_b, e_c;
    string e_tag;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_c    <= 0;
            m_down <= 0;
            m_h    <= (half_period == 0) ? 1 : int'(half_period);
            m_mode <= int'(mode_sel);
            e_a <= '0; e_b <= '0; e_c <= '0;
            e_tag <= "R12";
        end else begin
            e_a <= exp_bits(int'(ref_a), m_c, m_h, m_mode);
            e_b <= exp_bits(int'(ref_b), m_c, m_h, m_mode);
            e_c <= exp_bits(int'(ref_c), m_c, m_h, m_mode);
            if (int'(mode_sel) != m_mode || ((half_period == 0) ? 1 : int'(half_period)) != m_h)
                e_tag <= "R10";
            else if (half_period == 0) e_tag <= "R2";
            else case (m_mode)
                0: e_tag <= "R3";
                1: e_tag <= "R4";
                2: e_tag <= "R5";
                default: e_tag <= "R6";
            endcase
            if (!m_down) begin
                m_c <= m_c + 1;
                if (m_c + 1 >= m_h) m_down <= 1;
            end else begin
                m_c <= m_c - 1;
                if (m_c == 1) begin
                    m_down <= 0;
                    m_h    <= (half_period == 0) ? 1 : int'(half_period);
                    m_mode <= int'(mode_sel);
                end
            end
        end
    end

    // ---------------- checking ----------------
    task automatic check(string tag, string what, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic check_outputs();
        check(e_tag, "phase a bits", int'(cmp_a), int'(e_a));
        check("R9",  "phase b bits", int'(cmp_b), int'(e_b));
        check("R7",  "phase c bits", int'(cmp_c), int'(e_c));
        check("R8",  "phase a level", int'(level_a), exp_level(e_a));
        check("R8",  "phase b level", int'(level_b), exp_level(e_b));
        check("R8",  "phase c level", int'(level_c), exp_level(e_c));
    endtask

    // one cycle: check at the falling edge, then drive new inputs
    task automatic cycle_check();
        @(negedge clk);
        check_outputs();
    endtask

    function automatic int rnd_ref(int h);
        int span = 4 * ((h == 0) ? 1 : h) + 3;
        return int'($urandom_range(2 * span)) - span;
    endfunction

    // ---------------- stimulus ----------------
    initial begin
        void'($urandom(32'd7321));
        repeat (3) @(negedge clk);
        // R12: reset state
        check("R12", "reset cmp_a", int'(cmp_a), 0);
        check("R12", "reset level_b", int'(level_b), -4);
        @(negedge clk);
        rst_n = 1'b1;

        // R11: one-cycle latency on a step of the reference
        ref_a = -12'sd2000;
        cycle_check();
        ref_a = 12'sd2000;
        check("R11", "cmp_a before edge", int'(cmp_a), 0);
        cycle_check();
        check("R11", "cmp_a after edge", int'(cmp_a), 255);
        check("R11", "level_a after edge", int'(level_a), 4);

        // R1: aligned mode, H=10, reference 5 sits inside band 4
        mode_sel = 2'd0; half_period = 8'd10; ref_a = 12'sd5; ref_b = 12'sd5; ref_c = 12'sd5;
        repeat (60) begin
            cycle_check();
            check("R1", "bands 0-3 set, 5-7 clear", int'(cmp_a & 8'hEF), 8'h0F);
        end

        // R7: reference equal to a carrier's band edge value gives 0 at the tie
        half_period = 8'd2;
        repeat (40) begin
            cycle_check();
            ref_a = 12'(2 * (int'($urandom_range(8)) - 4));
            ref_b = ref_a;
            ref_c = 12'(int'($urandom_range(16)) - 8);
        end

        // random runs across modes and half-periods, with mid-period changes
        for (int run = 0; run < 40; run++) begin
            half_period = (run == 39) ? 8'd200 : 8'($urandom_range(11));
            mode_sel    = 2'($urandom_range(3));
            for (int i = 0; i < 150; i++) begin
                cycle_check();
                if ($urandom_range(19) == 0) mode_sel = 2'($urandom_range(3));
                if ($urandom_range(39) == 0) half_period = 8'($urandom_range(11));
                ref_a = 12'(rnd_ref(int'(half_period)));
                ref_b = ($urandom_range(3) == 0) ? ref_a : 12'(rnd_ref(int'(half_period)));
                ref_c = 12'(rnd_ref(int'(half_period)));
            end
        end

        // extremes: full scale in both directions
        ref_a = 12'sh7FF; ref_b = 12'sh800; ref_c = 12'sd0;
        cycle_check();
        cycle_check();
        check("R8", "max level", int'(level_a), 4);
        check("R8", "min level", int'(level_b), -4);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule